// File: doc/BRIEF.md
# Dual Limit-Compare Wait Timer

This block gives a command sequencer two timed waits. Each of the two timers owns a 16-bit limit. A one-cycle start request arms a timer. The timer then advances once per divided tick. It raises a one-cycle done pulse in the tick where its count already equals its limit. After that pulse the count clears and the timer goes idle, ready for the next wait.

The sequencer can change a limit between waits without any processor help. An add request sums a shared adjust register into the chosen limit. A copy request loads a shared hold register into it. Using these requests, a loop of waits can stretch or reset its own period.

The tick is built in two stages. One of several incoming strobe sources is selected, and a divider then passes one tick for every N+1 selected strobes. Dropping the enable clears both counts and the divider phase, and aborts any wait in progress. Limit, adjust and hold values are kept while the enable is low.

Top module: `wtmr_top`

## Requirements
- R1: After synchronous reset, both done outputs are 0, both counts are 0, and both limits, the adjust register and the hold register are 0.
- R2: With limit L and divider ratio D, a timer armed by start_i asserts done_o on the (L+1)*(D+1)-th selected strobe after the arming cycle, when the divider phase was cleared by a low enable beforehand. done_o is combinational and appears in that strobe's own cycle.
- R3: done_o for a timer lasts exactly one cycle. In the following cycle the count reads 0, and no further done appears until the timer is re-armed.
- R4: Only the strobe bit whose index equals src_sel_i advances the divider. Strobes on the other source bits have no effect on timing.
- R5: The divider emits one tick for every div_ratio_i+1 selected strobes. Cycles that carry no selected strobe leave the count unchanged.
- R6: An add request sets limit <= (limit + adjust) mod 2^16, with no saturation.
- R7: A copy request loads the hold register value into the limit.
- R8: Limit update priority per timer is: direct write (lim_wr_i with lim_wdata_i) first, then copy, then add.
- R9: While enable_i is low, counts and the divider phase clear, any active wait is aborted, and start requests are ignored. Limits are retained.
- R10: A start request made while the timer is already waiting is ignored. The wait still ends on the original schedule.
- R11: The two timers run independently, and each one completes on its own limit.
- R12: A limit of zero completes the wait on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Module enable; when low, timers and the divider are cleared |
| src_sel_i | input | 2 | Index of the strobe source that feeds the divider |
| div_ratio_i | input | 4 | Divider ratio D; one tick per D+1 selected strobes |
| src_stb_i | input | 3 | Candidate count-rate strobes, one bit per source |
| start_i | input | 2 | Per-timer request to arm a wait |
| done_o | output | 2 | Per-timer one-cycle completion pulse |
| add_i | input | 2 | Per-timer request to add the adjust value to the limit |
| copy_i | input | 2 | Per-timer request to copy the hold value into the limit |
| lim_wr_i | input | 2 | Per-timer direct limit write |
| lim_wdata_i | input | 16 | Data for a direct limit write |
| adj_wr_i | input | 1 | Write strobe for the adjust register |
| adj_wdata_i | input | 16 | Adjust register data |
| hold_wr_i | input | 1 | Write strobe for the hold register |
| hold_wdata_i | input | 16 | Hold register data |
| cnt_o | output | 32 | Current counts, timer 0 in bits 15:0 |
| limit_o | output | 32 | Current limits, timer 0 in bits 15:0 |

## Verification
The properties take for granted two things about the inputs. First, a limit is not lowered below the running count in the middle of a wait. Second, the arithmetic check for an add treats the adjust value as the one held in the register in that cycle, so an adjust write in the same cycle does not count. The stimulus respects both conditions. Every limit write, add and copy is issued while the target timer is idle. Adjust and hold writes are always made in separate cycles from the requests that use them. Each timed wait begins with a one-cycle drop of enable, so the divider phase is known and the expected strobe count can be computed as (L+1)*(D+1).

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

    typedef enum logic [1:0] {
        LIM_KEEP = 2'd0,
        LIM_LOAD = 2'd1,
        LIM_COPY = 2'd2,
        LIM_ADD  = 2'd3
    } lim_op_e;

    typedef struct packed {
        logic busy;
        logic hit;
    } wait_state_t;

    // direct write beats copy, copy beats add
    function automatic lim_op_e lim_op_sel(input logic wr, input logic cp, input logic ad);
        if (wr)      return LIM_LOAD;
        else if (cp) return LIM_COPY;
        else if (ad) return LIM_ADD;
        else         return LIM_KEEP;
    endfunction

    function automatic int sel_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wtmr_tick_div.sv
module wtmr_tick_div
    import wtmr_pkg::*;
#(
    parameter int NSRC  = 3,
    parameter int DIV_W = 4,
    localparam int SEL_W = sel_bits(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [NSRC-1:0]  src_stb,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    localparam int EXT_N = 1 << SEL_W;

    logic [EXT_N-1:0] stb_ext;
    logic             stb;
    logic [DIV_W-1:0] phase_q;

    always_comb begin
        stb_ext             = '0;
        stb_ext[NSRC-1:0]   = src_stb;
        stb                 = stb_ext[sel];
        tick                = en && stb && (phase_q == ratio);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= '0;
        end else if (stb) begin
            phase_q <= (phase_q == ratio) ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/wtmr_unit.sv
module wtmr_unit
    import wtmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic          start,
    input  logic          wr,
    input  logic          cp,
    input  logic          ad,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] adj,
    input  logic [CW-1:0] hold,
    output logic          done,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] lim
);
    wait_state_t st;
    logic        busy_q;
    lim_op_e     op;

    always_comb begin
        st.busy = busy_q;
        st.hit  = busy_q && tick && (cnt == lim);
        done    = st.hit;
        op      = lim_op_sel(wr, cp, ad);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lim <= '0;
        end else begin
            case (op)
                LIM_LOAD: lim <= wdata;
                LIM_COPY: lim <= hold;
                LIM_ADD:  lim <= lim + adj;
                default:  lim <= lim;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (!st.busy) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt    <= '0;
            end
        end else if (tick) begin
            if (st.hit) begin
                busy_q <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wtmr_top.sv
module wtmr_top
    import wtmr_pkg::*;
#(
    parameter int NT    = 2,
    parameter int CW    = 16,
    parameter int NSRC  = 3,
    parameter int DIV_W = 4,
    localparam int SEL_W = sel_bits(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic [DIV_W-1:0] div_ratio_i,
    input  logic [NSRC-1:0]  src_stb_i,
    input  logic [NT-1:0]    start_i,
    output logic [NT-1:0]    done_o,
    input  logic [NT-1:0]    add_i,
    input  logic [NT-1:0]    copy_i,
    input  logic [NT-1:0]    lim_wr_i,
    input  logic [CW-1:0]    lim_wdata_i,
    input  logic             adj_wr_i,
    input  logic [CW-1:0]    adj_wdata_i,
    input  logic             hold_wr_i,
    input  logic [CW-1:0]    hold_wdata_i,
    output logic [NT*CW-1:0] cnt_o,
    output logic [NT*CW-1:0] limit_o
);
    logic          tick;
    logic [CW-1:0] adj_q;
    logic [CW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            adj_q  <= '0;
            hold_q <= '0;
        end else begin
            if (adj_wr_i)  adj_q  <= adj_wdata_i;
            if (hold_wr_i) hold_q <= hold_wdata_i;
        end
    end

    wtmr_tick_div #(.NSRC(NSRC), .DIV_W(DIV_W)) div_i (
        .clk     (clk),
        .rst     (rst),
        .en      (enable_i),
        .src_stb (src_stb_i),
        .sel     (src_sel_i),
        .ratio   (div_ratio_i),
        .tick    (tick)
    );

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        wtmr_unit #(.CW(CW)) unit_i (
            .clk   (clk),
            .rst   (rst),
            .en    (enable_i),
            .tick  (tick),
            .start (start_i[t]),
            .wr    (lim_wr_i[t]),
            .cp    (copy_i[t]),
            .ad    (add_i[t]),
            .wdata (lim_wdata_i),
            .adj   (adj_q),
            .hold  (hold_q),
            .done  (done_o[t]),
            .cnt   (cnt_o[t*CW +: CW]),
            .lim   (limit_o[t*CW +: CW])
        );
    end

endmodule

// File: rtl/wtmr_chk.sv
module wtmr_chk #(
    parameter int NT = 2,
    parameter int CW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enable_i,
    input logic [NT-1:0]    done_o,
    input logic [NT-1:0]    add_i,
    input logic [NT-1:0]    copy_i,
    input logic [NT-1:0]    lim_wr_i,
    input logic [CW-1:0]    lim_wdata_i,
    input logic [CW-1:0]    adj_q,
    input logic [CW-1:0]    hold_q,
    input logic [NT*CW-1:0] cnt_o,
    input logic [NT*CW-1:0] limit_o
);
    for (genvar i = 0; i < NT; i++) begin : g_c
        // R3
        done_single_chk: assert property (@(posedge clk) disable iff (rst)
            done_o[i] |=> !done_o[i]);
        // R3
        done_clear_chk: assert property (@(posedge clk) disable iff (rst)
            done_o[i] |=> (cnt_o[i*CW +: CW] == '0));
        // R9
        disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
            !enable_i |=> (cnt_o[i*CW +: CW] == '0) && !done_o[i]);
        // R6
        add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (add_i[i] && !copy_i[i] && !lim_wr_i[i]) |=>
            (limit_o[i*CW +: CW] == CW'($past(limit_o[i*CW +: CW]) + $past(adj_q))));
        // R7
        copy_load_chk: assert property (@(posedge clk) disable iff (rst)
            (copy_i[i] && !lim_wr_i[i]) |=> (limit_o[i*CW +: CW] == $past(hold_q)));
        // R8
        write_first_chk: assert property (@(posedge clk) disable iff (rst)
            lim_wr_i[i] |=> (limit_o[i*CW +: CW] == $past(lim_wdata_i)));
        // R9
        limit_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (!lim_wr_i[i] && !copy_i[i] && !add_i[i]) |=> $stable(limit_o[i*CW +: CW]));
    end
endmodule

bind wtmr_top wtmr_chk #(.NT(NT), .CW(CW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .enable_i    (enable_i),
    .done_o      (done_o),
    .add_i       (add_i),
    .copy_i      (copy_i),
    .lim_wr_i    (lim_wr_i),
    .lim_wdata_i (lim_wdata_i),
    .adj_q       (adj_q),
    .hold_q      (hold_q),
    .cnt_o       (cnt_o),
    .limit_o     (limit_o)
);

// File: tb/wtmr_top_tb_top.sv
module wtmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        enable_i;
    logic [1:0]  src_sel_i;
    logic [3:0]  div_ratio_i;
    logic [2:0]  src_stb_i;
    logic [1:0]  start_i, done_o, add_i, copy_i, lim_wr_i;
    logic [15:0] lim_wdata_i, adj_wdata_i, hold_wdata_i;
    logic        adj_wr_i, hold_wr_i;
    logic [31:0] cnt_o, limit_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wtmr_top dut_i (
        .clk(clk), .rst(rst), .enable_i(enable_i), .src_sel_i(src_sel_i),
        .div_ratio_i(div_ratio_i), .src_stb_i(src_stb_i), .start_i(start_i),
        .done_o(done_o), .add_i(add_i), .copy_i(copy_i), .lim_wr_i(lim_wr_i),
        .lim_wdata_i(lim_wdata_i), .adj_wr_i(adj_wr_i), .adj_wdata_i(adj_wdata_i),
        .hold_wr_i(hold_wr_i), .hold_wdata_i(hold_wdata_i),
        .cnt_o(cnt_o), .limit_o(limit_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lim_of(input int t);
        return limit_o[t*16 +: 16];
    endfunction

    function automatic logic [15:0] cnt_of(input int t);
        return cnt_o[t*16 +: 16];
    endfunction

    task automatic idle_all();
        start_i = '0; add_i = '0; copy_i = '0; lim_wr_i = '0;
        adj_wr_i = 1'b0; hold_wr_i = 1'b0; src_stb_i = '0;
    endtask

    // one cycle: drive at the falling edge, sample done just after
    task automatic pulse(input logic [2:0] stb, input logic [1:0] st, output logic [1:0] d);
        @(negedge clk);
        idle_all();
        src_stb_i = stb;
        start_i   = st;
        #1 d = done_o;
    endtask

    task automatic step_idle();
        @(negedge clk);
        idle_all();
    endtask

    // R2 R4 R5 R12 R3: timed wait from a cleared divider phase
    task automatic run_wait(input int t, input int src, input int d, input int l, input bit gap);
        logic [2:0] others;
        logic [1:0] dd;
        int n, first, total;
        n = (l + 1) * (d + 1);
        others = 3'b111 & ~(3'(1) << src);
        @(negedge clk);
        idle_all();
        enable_i = 1'b0; src_sel_i = 2'(src); div_ratio_i = 4'(d);
        lim_wr_i[t] = 1'b1; lim_wdata_i = 16'(l);
        @(negedge clk);
        idle_all();
        enable_i = 1'b1; start_i[t] = 1'b1;
        first = 0; total = 0;
        for (int k = 1; k <= n + 3; k++) begin
            if (gap) begin
                pulse(others, 2'b00, dd);
                if (dd[t]) total++;
            end
            pulse(others | (3'(1) << src), 2'b00, dd);
            if (dd[t]) begin
                total++;
                if (first == 0) first = k;
            end
        end
        step_idle();
        chk(first == n, "R2/R5 done strobe index", first, n);
        chk(total == 1, "R3 single done per wait", total, 1);
        chk(cnt_of(t) == 0, "R3 count cleared after done", cnt_of(t), 0);
    endtask

    initial begin
        logic [1:0] dd;
        int n0, n1, first;
        rst = 1'b1; enable_i = 1'b0; src_sel_i = '0; div_ratio_i = '0;
        lim_wdata_i = '0; adj_wdata_i = '0; hold_wdata_i = '0;
        idle_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(done_o == 2'b00, "R1 done at reset", done_o, 0);
        chk(cnt_o == 32'd0, "R1 counts at reset", cnt_o, 0);
        chk(limit_o == 32'd0, "R1 limits at reset", limit_o, 0);
        // R1: adjust reads zero -> add keeps limit 0
        @(negedge clk); idle_all(); add_i = 2'b11;
        step_idle(); #1;
        chk(limit_o == 32'd0, "R1 adjust zero at reset", limit_o, 0);
        // R1: hold reads zero -> copy over a nonzero limit gives 0
        @(negedge clk); idle_all(); lim_wr_i = 2'b01; lim_wdata_i = 16'h00AA;
        @(negedge clk); idle_all(); copy_i = 2'b01;
        step_idle(); #1;
        chk(lim_of(0) == 0, "R1 hold zero at reset", lim_of(0), 0);

        // sweep: timer, source, divider ratio, limit (R2 R4 R5 R12)
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 3; s++)
                for (int d = 0; d < 4; d++)
                    for (int l = 0; l < 7; l++)
                        run_wait(t, s, d, l, bit'(l % 2));

        // R6 add wraps modulo 2^16
        @(negedge clk); idle_all(); lim_wr_i = 2'b01; lim_wdata_i = 16'hFFF0;
        @(negedge clk); idle_all(); adj_wr_i = 1'b1; adj_wdata_i = 16'h0020;
        @(negedge clk); idle_all(); add_i = 2'b01;
        step_idle(); #1;
        chk(lim_of(0) == 16'h0010, "R6 add wrap", lim_of(0), 16'h0010);
        @(negedge clk); idle_all(); add_i = 2'b01;
        step_idle(); #1;
        chk(lim_of(0) == 16'h0030, "R6 second add", lim_of(0), 16'h0030);

        // R7 copy from hold
        @(negedge clk); idle_all(); hold_wr_i = 1'b1; hold_wdata_i = 16'h1234;
        @(negedge clk); idle_all(); copy_i = 2'b10;
        step_idle(); #1;
        chk(lim_of(1) == 16'h1234, "R7 copy hold", lim_of(1), 16'h1234);

        // R8 priority: write over copy, copy over add
        @(negedge clk); idle_all(); lim_wr_i = 2'b01; copy_i = 2'b01; add_i = 2'b01;
        lim_wdata_i = 16'h0077;
        step_idle(); #1;
        chk(lim_of(0) == 16'h0077, "R8 write wins", lim_of(0), 16'h0077);
        @(negedge clk); idle_all(); hold_wr_i = 1'b1; hold_wdata_i = 16'h0500;
        @(negedge clk); idle_all(); copy_i = 2'b10; add_i = 2'b10;
        step_idle(); #1;
        chk(lim_of(1) == 16'h0500, "R8 copy beats add", lim_of(1), 16'h0500);

        // R10 start while waiting is ignored
        @(negedge clk); idle_all(); enable_i = 1'b0; src_sel_i = 2'd0; div_ratio_i = 4'd0;
        lim_wr_i = 2'b01; lim_wdata_i = 16'd3;
        @(negedge clk); idle_all(); enable_i = 1'b1; start_i = 2'b01;
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            pulse(3'b001, (k == 3) ? 2'b01 : 2'b00, dd);
            if (dd[0] && first == 0) first = k;
        end
        chk(first == 4, "R10 restart ignored", first, 4);

        // R11 independent timers
        @(negedge clk); idle_all(); enable_i = 1'b0; lim_wr_i = 2'b11; lim_wdata_i = 16'd1;
        @(negedge clk); idle_all(); lim_wr_i = 2'b10; lim_wdata_i = 16'd3;
        @(negedge clk); idle_all(); enable_i = 1'b1; start_i = 2'b11;
        n0 = 0; n1 = 0;
        for (int k = 1; k <= 8; k++) begin
            pulse(3'b001, 2'b00, dd);
            if (dd[0] && n0 == 0) n0 = k;
            if (dd[1] && n1 == 0) n1 = k;
        end
        chk(n0 == 2, "R11 timer0 done", n0, 2);
        chk(n1 == 4, "R11 timer1 done", n1, 4);

        // R9 disable aborts, blocks start, keeps limit
        @(negedge clk); idle_all(); lim_wr_i = 2'b01; lim_wdata_i = 16'd5;
        @(negedge clk); idle_all(); start_i = 2'b01;
        pulse(3'b001, 2'b00, dd);
        pulse(3'b001, 2'b00, dd);
        step_idle(); #1;
        chk(cnt_of(0) == 16'd2, "R9 count before disable", cnt_of(0), 2);
        @(negedge clk); idle_all(); enable_i = 1'b0; start_i = 2'b01;
        step_idle(); enable_i = 1'b1; #1;
        chk(cnt_of(0) == 16'd0, "R9 count cleared", cnt_of(0), 0);
        chk(lim_of(0) == 16'd5, "R9 limit kept", lim_of(0), 5);
        n0 = 0;
        for (int k = 1; k <= 12; k++) begin
            pulse(3'b001, 2'b00, dd);
            if (dd[0]) n0++;
        end
        chk(n0 == 0, "R9 wait aborted and start ignored", n0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule